// File: doc/BRIEF.md
# Parallel Programming Host Sequencer

This block is the host side of a byte-wide parallel programming link to a flash target. It takes one request at a time over a valid/ready handshake. A request is either a full chip erase or a write of one 16-bit flash word at a word address. The block turns each request into the ordered strobe sequence the target expects. It drives a 2-bit action selector, a byte selector, an 8-bit data bus, an active-high load strobe and an active-low write strobe. Every bus setting is held for a fixed number of setup cycles before its strobe, and it stays unchanged for as long as the strobe lasts.

A word write is built from up to seven steps, in this order:
1. Command load.
2. Address high byte load.
3. Address low byte load.
4. Low data byte load.
5. Low byte write.
6. High data byte load.
7. High byte write.

After each byte write, the block waits for the target's ready/busy line to fall and then rise before it moves on. A counter bounds this wait. If the target never answers, the block raises an error pulse and drops back to idle.

The block remembers that the write command is loaded, together with the last address high byte. A later write skips whatever the target already holds. A chip erase loads the erase command and then holds the write strobe low for a timed width. It never looks at ready/busy.

Top module: `pp_host_seq`

## Requirements
- R1: After reset, req_ready is 1, pp_load is 0, pp_wr_n is 1, and done and err are 0.
- R2: A chip erase produces exactly two strobes, both with pp_xa=2'b10, pp_bs=0 and pp_data=8'h80. The first is a load, then pp_wr_n stays low for exactly ERASE_CYC cycles.
- R3: A chip erase completes with one done pulse while ready/busy stays high throughout; the target is never waited on.
- R4: When no command is held, a word write produces seven strobes in this order. Each is written here as (kind, pp_xa, pp_bs, pp_data).
  - (load, 10, 0, 8'h10)
  - (load, 00, 1, addr[15:8])
  - (load, 00, 0, addr[7:0])
  - (load, 01, 0, data[7:0])
  - (write, 01, 0, data[7:0])
  - (load, 01, 0, data[15:8])
  - (write, 01, 1, data[15:8])
- R5: After each byte write strobe, no further strobe occurs until pp_rdy has gone low and then high again. If pp_rdy never goes low, the sequence does not advance.
- R6: After a completed word write, a write whose addr[15:8] equals the previous one starts at the address low byte load and produces five strobes.
- R7: After a completed word write, a write with a different addr[15:8] skips the command and produces six strobes, starting at the address high byte load.
- R8: Each load strobe lasts LOAD_CYC cycles, each byte write strobe lasts WR_CYC cycles, and the bus values are stable for at least SETUP_CYC cycles before every strobe.
- R9: If a byte write gets no ready/busy completion within TIMEOUT_CYC cycles, err pulses for one cycle, no done is given, no further strobe follows, and the next write starts again with the command load.
- R10: req_ready is low from the cycle after a request is accepted until its sequence ends. Each completed request gives exactly one one-cycle done pulse.
- R11: After a chip erase, the next word write starts again with the command load, even if its address high byte matches the last write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle (idle) |
| req_erase | input | 1 | 1 = chip erase, 0 = word write |
| req_addr | input | ADDR_W | Flash word address |
| req_data | input | 16 | Flash word to write |
| done | output | 1 | One-cycle pulse when a request's sequence finished |
| err | output | 1 | One-cycle pulse when ready/busy timed out |
| pp_xa | output | 2 | Action select: 00 address, 01 data, 10 command |
| pp_bs | output | 1 | Byte select: 1 high byte, 0 low byte |
| pp_data | output | 8 | Programming data bus |
| pp_load | output | 1 | Active-high load strobe |
| pp_wr_n | output | 1 | Active-low write strobe |
| pp_rdy | input | 1 | Target ready (1) / busy (0) |

## Verification
The first write runs with no command held, so all seven strobes appear and every encoding can be checked. The writes that follow tell apart the three start points:
- an unchanged address high byte starts at the address low byte;
- a new address high byte starts at the address high byte;
- a write after an erase or a timeout starts again at the command.

A target model that answers each byte write with a busy pulse shows that the sequencer waits for the full low-then-high cycle. A silent target exposes the timeout path. An erase with ready/busy held high shows that the erase finishes on its timed pulse alone.

// File: rtl/pp_host_pkg.sv
package pp_host_pkg;

  typedef enum logic [3:0] {
    PH_CMD, PH_AHI, PH_ALO, PH_DLO, PH_WLO, PH_DHI, PH_WHI, PH_ECMD, PH_EWR
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_BUSY
  } step_e;

  localparam logic [7:0] OP_ERASE = 8'h80;
  localparam logic [7:0] OP_WRITE = 8'h10;

  localparam logic [1:0] SEL_ADDR = 2'b00;
  localparam logic [1:0] SEL_DATA = 2'b01;
  localparam logic [1:0] SEL_OP   = 2'b10;

endpackage

// File: rtl/pp_phase_decode.sv
module pp_phase_decode
  import pp_host_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  phase_e            phase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [1:0]        xa,
  output logic              bs,
  output logic [7:0]        bus,
  output logic              is_write,
  output logic              is_last,
  output phase_e            next_phase
);

  localparam int HI_W = ADDR_W - 8;

  logic [7:0] addr_hi;
  assign addr_hi = 8'(addr[ADDR_W-1 -: HI_W]);

  always_comb begin
    xa         = SEL_OP;
    bs         = 1'b0;
    bus        = OP_WRITE;
    is_write   = 1'b0;
    is_last    = 1'b0;
    next_phase = PH_CMD;
    case (phase)
      PH_CMD:  begin
        next_phase = PH_AHI;
      end
      PH_AHI:  begin
        xa         = SEL_ADDR;
        bs         = 1'b1;
        bus        = addr_hi;
        next_phase = PH_ALO;
      end
      PH_ALO:  begin
        xa         = SEL_ADDR;
        bus        = addr[7:0];
        next_phase = PH_DLO;
      end
      PH_DLO:  begin
        xa         = SEL_DATA;
        bus        = wdata[7:0];
        next_phase = PH_WLO;
      end
      PH_WLO:  begin
        xa         = SEL_DATA;
        bus        = wdata[7:0];
        is_write   = 1'b1;
        next_phase = PH_DHI;
      end
      PH_DHI:  begin
        xa         = SEL_DATA;
        bus        = wdata[15:8];
        next_phase = PH_WHI;
      end
      PH_WHI:  begin
        xa         = SEL_DATA;
        bs         = 1'b1;
        bus        = wdata[15:8];
        is_write   = 1'b1;
        is_last    = 1'b1;
      end
      PH_ECMD: begin
        bus        = OP_ERASE;
        next_phase = PH_EWR;
      end
      PH_EWR:  begin
        bus        = OP_ERASE;
        is_write   = 1'b1;
        is_last    = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pp_cycle_timer.sv
module pp_cycle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = len - 1'b1;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R8: a loaded length must leave the counter non-expired for len > 1
  p_len_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && len > 1) |=> !expired);

endmodule

// File: rtl/pp_busy_watch.sv
module pp_busy_watch #(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rdy_async,
  output logic ok,
  output logic tmo
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {W_IDLE, W_LO, W_HI} wstate_e;

  wstate_e       st_q, st_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          rdy_s1_q, rdy_s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_s1_q <= 1'b1;
      rdy_s2_q <= 1'b1;
    end else begin
      rdy_s1_q <= rdy_async;
      rdy_s2_q <= rdy_s1_q;
    end
  end

  assign ok  = (st_q == W_HI) && rdy_s2_q;
  assign tmo = (st_q != W_IDLE) && !ok && (tcnt_q == TW'(TIMEOUT_CYC - 1));

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    if (start) begin
      st_d   = W_LO;
      tcnt_d = '0;
    end else if (ok || tmo) begin
      st_d   = W_IDLE;
    end else if (st_q != W_IDLE) begin
      tcnt_d = tcnt_q + 1'b1;
      if (st_q == W_LO && !rdy_s2_q) st_d = W_HI;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      tcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
    end
  end

  // R5: completion is never reported in the cycle right after a wait starts
  p_no_early_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ok);

  // R9: the wait counter never passes the timeout limit
  p_tmo_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != W_IDLE) |-> (tcnt_q < TW'(TIMEOUT_CYC)));

endmodule

// File: rtl/pp_host_seq.sv
module pp_host_seq
  import pp_host_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SETUP_CYC   = 2,
  parameter int LOAD_CYC    = 2,
  parameter int WR_CYC      = 3,
  parameter int ERASE_CYC   = 64,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_erase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_data,
  output logic              done,
  output logic              err,
  output logic [1:0]        pp_xa,
  output logic              pp_bs,
  output logic [7:0]        pp_data,
  output logic              pp_load,
  output logic              pp_wr_n,
  input  logic              pp_rdy
);

  localparam int HI_W    = ADDR_W - 8;
  localparam int MAX_A   = (SETUP_CYC > LOAD_CYC) ? SETUP_CYC : LOAD_CYC;
  localparam int MAX_B   = (WR_CYC > ERASE_CYC) ? WR_CYC : ERASE_CYC;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  step_e             step_q, step_d;
  phase_e            phase_q, phase_d, next_phase;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [15:0]       data_q, data_d;
  logic              op_held_q, op_held_d;
  logic [HI_W-1:0]   page_q, page_d;
  logic              done_q, done_d, err_q, err_d;

  logic              tmr_load, tmr_exp;
  logic [CNT_W-1:0]  tmr_len, strobe_len;
  logic              w_start, w_ok, w_tmo;
  logic [1:0]        dec_xa;
  logic              dec_bs, is_write, is_last;
  logic [7:0]        dec_bus;

  pp_phase_decode #(.ADDR_W(ADDR_W)) u_dec (
    .phase(phase_q), .addr(addr_q), .wdata(data_q),
    .xa(dec_xa), .bs(dec_bs), .bus(dec_bus),
    .is_write(is_write), .is_last(is_last), .next_phase(next_phase)
  );

  pp_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expired(tmr_exp)
  );

  pp_busy_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
    .clk(clk), .rst_n(rst_n), .start(w_start), .rdy_async(pp_rdy),
    .ok(w_ok), .tmo(w_tmo)
  );

  assign strobe_len = !is_write          ? CNT_W'(LOAD_CYC)  :
                      (phase_q == PH_EWR) ? CNT_W'(ERASE_CYC) : CNT_W'(WR_CYC);

  always_comb begin
    step_d    = step_q;
    phase_d   = phase_q;
    addr_d    = addr_q;
    data_d    = data_q;
    op_held_d = op_held_q;
    page_d    = page_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    tmr_load  = 1'b0;
    tmr_len   = CNT_W'(SETUP_CYC);
    w_start   = 1'b0;
    case (step_q)
      ST_IDLE: if (req_valid) begin
        addr_d   = req_addr;
        data_d   = req_data;
        step_d   = ST_SETUP;
        tmr_load = 1'b1;
        if (req_erase)                                     phase_d = PH_ECMD;
        else if (op_held_q && req_addr[ADDR_W-1 -: HI_W] == page_q) phase_d = PH_ALO;
        else if (op_held_q)                                phase_d = PH_AHI;
        else                                               phase_d = PH_CMD;
      end
      ST_SETUP: if (tmr_exp) begin
        step_d   = ST_STROBE;
        tmr_load = 1'b1;
        tmr_len  = strobe_len;
      end
      ST_STROBE: if (tmr_exp) begin
        if (phase_q == PH_EWR) begin
          step_d    = ST_IDLE;
          done_d    = 1'b1;
          op_held_d = 1'b0;
        end else if (is_write) begin
          step_d  = ST_BUSY;
          w_start = 1'b1;
        end else begin
          phase_d  = next_phase;
          step_d   = ST_SETUP;
          tmr_load = 1'b1;
        end
      end
      ST_BUSY: begin
        if (w_tmo) begin
          step_d    = ST_IDLE;
          err_d     = 1'b1;
          op_held_d = 1'b0;
        end else if (w_ok && is_last) begin
          step_d    = ST_IDLE;
          done_d    = 1'b1;
          op_held_d = 1'b1;
          page_d    = addr_q[ADDR_W-1 -: HI_W];
        end else if (w_ok) begin
          phase_d  = next_phase;
          step_d   = ST_SETUP;
          tmr_load = 1'b1;
        end
      end
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q    <= ST_IDLE;
      phase_q   <= PH_CMD;
      addr_q    <= '0;
      data_q    <= '0;
      op_held_q <= 1'b0;
      page_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      step_q    <= step_d;
      phase_q   <= phase_d;
      op_held_q <= op_held_d;
      page_q    <= page_d;
      done_q    <= done_d;
      err_q     <= err_d;
      if (step_q == ST_IDLE) begin
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end
  end

  assign req_ready = (step_q == ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign pp_xa     = (step_q == ST_IDLE) ? 2'b00 : dec_xa;
  assign pp_bs     = (step_q == ST_IDLE) ? 1'b0  : dec_bs;
  assign pp_data   = (step_q == ST_IDLE) ? 8'h00 : dec_bus;
  assign pp_load   = (step_q == ST_STROBE) && !is_write;
  assign pp_wr_n   = !((step_q == ST_STROBE) && is_write);

  // R8: the two strobes are never active together
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pp_load && !pp_wr_n));

  // R8: bus values do not move while a strobe is active
  p_bus_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_STROBE) |-> $stable({pp_xa, pp_bs, pp_data}));

  // R10: an accepted request takes the block out of idle
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10: done and err never pulse together
  p_done_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R3: the erase write phase never enters the ready/busy wait
  p_erase_nowait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EWR) |-> (step_q != ST_BUSY));

endmodule

// File: tb/pp_host_seq_tb.sv
module pp_host_seq_tb;

  localparam int CLK_PERIOD  = 10;
  localparam int SETUP_CYC   = 2;
  localparam int LOAD_CYC    = 2;
  localparam int WR_CYC      = 3;
  localparam int ERASE_CYC   = 40;
  localparam int TIMEOUT_CYC = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_erase = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic        done, err;
  logic [1:0]  pp_xa;
  logic        pp_bs;
  logic [7:0]  pp_data;
  logic        pp_load, pp_wr_n;
  logic        pp_rdy = 1'b1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // target and monitor state (written only by the monitor block)
  logic [11:0] ev_log [0:63];
  int          ev_n = 0;
  int          setup_bad = 0, width_bad = 0, busy_bad = 0;
  int          n_done = 0, n_err = 0, n_rdy_low = 0;
  int          last_wr_w = 0;
  // target answer mode, written only by the tasks: 1 = busy pulse, 0 = silent
  int          tmode = 1;

  pp_host_seq #(
    .ADDR_W(16), .SETUP_CYC(SETUP_CYC), .LOAD_CYC(LOAD_CYC), .WR_CYC(WR_CYC),
    .ERASE_CYC(ERASE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_addr(req_addr), .req_data(req_data),
    .done(done), .err(err), .pp_xa(pp_xa), .pp_bs(pp_bs), .pp_data(pp_data),
    .pp_load(pp_load), .pp_wr_n(pp_wr_n), .pp_rdy(pp_rdy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] ev(input logic w, input logic [1:0] xa,
                                     input logic b, input logic [7:0] d);
    return {w, xa, b, d};
  endfunction

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor and target model, sampled away from the active edge
  logic [10:0] prev_bus = '0;
  logic        prev_load = 1'b0, prev_wr_n = 1'b1;
  int          stab = 0, lw = 0, ww = 0, tcnt = 0;
  logic        tbusy = 1'b0;

  always @(negedge clk) begin
    logic [10:0] cur_bus;
    logic        st_load, st_wr;
    cur_bus = {pp_xa, pp_bs, pp_data};
    if (cur_bus == prev_bus) stab++; else stab = 0;
    st_load = pp_load && !prev_load;
    st_wr   = !pp_wr_n && prev_wr_n;
    if (st_load || st_wr) begin
      if (stab < SETUP_CYC) setup_bad++;
      if (tbusy) busy_bad++;
      if (ev_n < 64) ev_log[ev_n] = ev(st_wr, pp_xa, pp_bs, pp_data);
      ev_n++;
    end
    if (pp_load) lw++;
    if (!pp_load && prev_load) begin
      if (lw != LOAD_CYC) width_bad++;
      lw = 0;
    end
    if (!pp_wr_n) ww++;
    if (pp_wr_n && !prev_wr_n) begin
      last_wr_w = ww;
      if (prev_bus[10:9] != 2'b10) begin
        if (ww != WR_CYC) width_bad++;
        if (tmode == 1) begin
          tbusy = 1'b1;
          tcnt  = 0;
        end
      end
      ww = 0;
    end
    if (tbusy) begin
      tcnt++;
      if (tcnt == 2) pp_rdy = 1'b0;
      if (tcnt == 7) begin
        pp_rdy = 1'b1;
        tbusy  = 1'b0;
      end
    end
    if (!pp_rdy) n_rdy_low++;
    if (done) n_done++;
    if (err)  n_err++;
    prev_bus  = cur_bus;
    prev_load = pp_load;
    prev_wr_n = pp_wr_n;
  end

  // issue one request and wait for its end; returns the index of its first event
  task automatic run_req(input logic erase, input logic [15:0] addr,
                         input logic [15:0] data, input string req, output int base);
    int lim;
    int d0, e0;
    base = ev_n;
    d0 = n_done;
    e0 = n_err;
    @(negedge clk);
    req_valid = 1'b1;
    req_erase = erase;
    req_addr  = addr;
    req_data  = data;
    forever begin
      @(posedge clk);
      if (req_ready) break;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {req, " R10 ready low while busy"}, req_ready, 0);
    lim = 0;
    while (n_done == d0 && n_err == e0 && lim < 3000) begin
      @(negedge clk);
      lim++;
    end
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, {req, " R10 ready back in idle"}, req_ready, 1);
  endtask

  task automatic check_tail(input int base, input int n, input logic [11:0] exp [7],
                            input int first, input string req);
    chk(ev_n - base == n, {req, " strobe count"}, ev_n - base, n);
    for (int i = 0; i < n; i++)
      if (base + i < 64)
        chk(ev_log[base+i] == exp[first+i], {req, " strobe order/encoding"},
            ev_log[base+i], exp[first+i]);
  endtask

  function automatic void word_seq(input logic [15:0] a, input logic [15:0] d,
                                   output logic [11:0] e [7]);
    e[0] = ev(0, 2'b10, 0, 8'h10);
    e[1] = ev(0, 2'b00, 1, a[15:8]);
    e[2] = ev(0, 2'b00, 0, a[7:0]);
    e[3] = ev(0, 2'b01, 0, d[7:0]);
    e[4] = ev(1, 2'b01, 0, d[7:0]);
    e[5] = ev(0, 2'b01, 0, d[15:8]);
    e[6] = ev(1, 2'b01, 1, d[15:8]);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(pp_load == 1'b0, "R1 pp_load", pp_load, 0);
    chk(pp_wr_n == 1'b1, "R1 pp_wr_n", pp_wr_n, 1);
    chk(done == 1'b0 && err == 1'b0, "R1 done/err", {done, err}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_word(input logic [15:0] a, input logic [15:0] d,
                        input int first, input string req);
    logic [11:0] e [7];
    int base, d0, sb, wb, bb;
    d0 = n_done; sb = setup_bad; wb = width_bad; bb = busy_bad;
    word_seq(a, d, e);
    run_req(1'b0, a, d, req, base);
    check_tail(base, 7 - first, e, first, req);
    chk(n_done - d0 == 1, {req, " R10 one done pulse"}, n_done - d0, 1);
    chk(setup_bad == sb, {req, " R8 setup before strobe"}, setup_bad - sb, 0);
    chk(width_bad == wb, {req, " R8 strobe width"}, width_bad - wb, 0);
    chk(busy_bad == bb, {req, " R5 strobe during target busy"}, busy_bad - bb, 0);
  endtask

  task automatic t_timeout();
    logic [11:0] e [7];
    int base, d0, e0;
    tmode = 0;
    d0 = n_done; e0 = n_err;
    word_seq(16'h0701, 16'h0F0F, e);
    run_req(1'b0, 16'h0701, 16'h0F0F, "R9", base);
    check_tail(base, 3, e, 2, "R9/R5 stops after low write");
    chk(n_err - e0 == 1, "R9 err pulse", n_err - e0, 1);
    chk(n_done == d0, "R9 no done", n_done - d0, 0);
    repeat (20) @(negedge clk);
    chk(ev_n - base == 3, "R9 no later strobe", ev_n - base, 3);
    tmode = 1;
  endtask

  task automatic t_erase();
    logic [11:0] e [7];
    int base, d0, r0;
    d0 = n_done; r0 = n_rdy_low;
    e[0] = ev(0, 2'b10, 0, 8'h80);
    e[1] = ev(1, 2'b10, 0, 8'h80);
    run_req(1'b1, 16'h0000, 16'h0000, "R2", base);
    check_tail(base, 2, e, 0, "R2 erase");
    chk(last_wr_w == ERASE_CYC, "R2 erase pulse width", last_wr_w, ERASE_CYC);
    chk(n_done - d0 == 1, "R3 done without ready/busy", n_done - d0, 1);
    chk(n_rdy_low == r0, "R3 ready/busy never low", n_rdy_low - r0, 0);
  endtask

  initial begin
    t_reset();
    t_word(16'h0312, 16'hBEEF, 0, "R4 cold write");
    t_word(16'h03A5, 16'h1234, 2, "R6 same page");
    t_word(16'h0700, 16'h5A5A, 1, "R7 new page");
    t_timeout();
    t_word(16'h0001, 16'hC3C3, 0, "R9 write after timeout");
    t_erase();
    t_word(16'h0002, 16'h9669, 0, "R11 write after erase");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

endmodule